// File: doc/BRIEF.md
# I/Q Word Assembler

This block turns a narrow stream of 6-bit words, one word per clock, into full-width 12-bit in-phase and quadrature samples. A symbol-start strobe marks the word that opens a symbol. Each 12-bit component is built from two words, upper half first. The I component comes first and the Q component follows. Components are two's complement, so the sign of each sample is the top bit of its first word.

Once the four words of a symbol have been taken in, the block presents the I and Q samples together on registered outputs with a one-clock valid pulse. Pairs therefore appear at one quarter of the word rate. A strobe that arrives partway through a symbol drops the partial symbol and starts a new one on the current word. Nothing is produced until the first strobe after reset.

Top module: `iq_word_assembler`

## Requirements
- R1: While reset is high, and in the first cycle after it, `pair_vld` is 0 and `i_out` and `q_out` are 0.
- R2: Until the first cycle in which `sym_start` is 1 after reset, input words are ignored and `pair_vld` stays 0.
- R3: The word presented with `sym_start` becomes `i_out[11:6]` and the next word becomes `i_out[5:0]`. `i_out` read as a signed value is negative exactly when bit 5 of the first word is 1.
- R4: The third word of a symbol becomes `q_out[11:6]` and the fourth becomes `q_out[5:0]`.
- R5: `pair_vld` is 1 for exactly one cycle, the cycle after the fourth word is captured. `i_out` and `q_out` change only in that cycle, and both change together.
- R6: After the fourth word, the next word opens a new symbol as its upper I half even when `sym_start` is 0. Words keep streaming with no gap between symbols.
- R7: `sym_start` during the second, third or fourth word of a symbol discards the words already collected, so no pair is produced for them. The word presented with that strobe becomes the upper I half of a new symbol.
- R8: Between any two cycles with `pair_vld` equal to 1 there are at least three cycles with `pair_vld` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; one word is taken on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sym_start | input | 1 | Marks the current word as the first word of a symbol |
| word_in | input | 6 | Input word |
| i_out | output | 12 | Assembled in-phase sample, two's complement |
| q_out | output | 12 | Assembled quadrature sample, two's complement |
| pair_vld | output | 1 | One-cycle pulse when a new I/Q pair is on the outputs |

## Verification
On every cycle the assertions check four things. No pair appears before the first strobe. Each pair equals the last four input words in upper-I, lower-I, upper-Q, lower-Q order. Valid pulses last one cycle and are spaced at least four cycles apart. The outputs hold steady while valid is low. Only the bench scenarios can show that a mid-symbol strobe discards the partial symbol rather than just shifting the word order. The same goes for symbols following each other back to back with no strobe, and for the reset values of the outputs.

// File: rtl/iqa_pkg.sv
package iqa_pkg;
  localparam int NUM_WORDS = 4;
  localparam int PH_W = $clog2(NUM_WORDS);

  typedef enum logic [PH_W-1:0] {
    PH_I_HI = 2'd0,
    PH_I_LO = 2'd1,
    PH_Q_HI = 2'd2,
    PH_Q_LO = 2'd3
  } phase_e;
endpackage

// File: rtl/iqa_sequencer.sv
module iqa_sequencer
  import iqa_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   sym_start,
  output logic   take,
  output phase_e cur_phase
);
  logic            armed_q;
  logic [PH_W-1:0] cnt_q;
  logic [PH_W-1:0] cur_raw;

  always_comb begin
    take      = armed_q | sym_start;
    cur_raw   = sym_start ? '0 : cnt_q;
    cur_phase = phase_e'(cur_raw);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (take) begin
      armed_q <= 1'b1;
      cnt_q   <= cur_raw + 1'b1;
    end
  end
endmodule

// File: rtl/iqa_packer.sv
module iqa_packer
  import iqa_pkg::*;
#(
  parameter int WORD_W = 6,
  localparam int COMP_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  phase_e            cur_phase,
  input  logic [WORD_W-1:0] word_in,
  output logic [COMP_W-1:0] i_out,
  output logic [COMP_W-1:0] q_out,
  output logic              pair_vld
);
  logic [WORD_W-1:0] hold_q [NUM_WORDS-1];
  logic              last_word;

  genvar g;
  generate
    for (g = 0; g < NUM_WORDS - 1; g++) begin : g_hold
      always_ff @(posedge clk) begin
        if (rst)
          hold_q[g] <= '0;
        else if (take && (cur_phase == phase_e'(g)))
          hold_q[g] <= word_in;
      end
    end
  endgenerate

  always_comb last_word = take && (cur_phase == PH_Q_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_vld <= 1'b0;
      i_out    <= '0;
      q_out    <= '0;
    end else begin
      pair_vld <= last_word;
      if (last_word) begin
        i_out <= {hold_q[0], hold_q[1]};
        q_out <= {hold_q[2], word_in};
      end
    end
  end
endmodule

// File: rtl/iq_word_assembler.sv
module iq_word_assembler
  import iqa_pkg::*;
#(
  parameter int WORD_W = 6,
  localparam int COMP_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sym_start,
  input  logic [WORD_W-1:0] word_in,
  output logic [COMP_W-1:0] i_out,
  output logic [COMP_W-1:0] q_out,
  output logic              pair_vld
);
  logic   take;
  phase_e cur_phase;

  iqa_sequencer u_seq (
    .clk       (clk),
    .rst       (rst),
    .sym_start (sym_start),
    .take      (take),
    .cur_phase (cur_phase)
  );

  iqa_packer #(.WORD_W(WORD_W)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .cur_phase (cur_phase),
    .word_in   (word_in),
    .i_out     (i_out),
    .q_out     (q_out),
    .pair_vld  (pair_vld)
  );
endmodule

// File: rtl/iqa_checker.sv
module iqa_checker #(
  parameter int WORD_W = 6,
  localparam int COMP_W = 2 * WORD_W
) (
  input logic              clk,
  input logic              rst,
  input logic              sym_start,
  input logic [WORD_W-1:0] word_in,
  input logic [COMP_W-1:0] i_out,
  input logic [COMP_W-1:0] q_out,
  input logic              pair_vld
);
  logic       seen_sync;
  logic [1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_sync <= 1'b0;
      gap       <= 2'd3;
    end else begin
      if (sym_start) seen_sync <= 1'b1;
      if (pair_vld) gap <= 2'd0;
      else if (gap != 2'd3) gap <= gap + 2'd1;
    end
  end

  // R2
  no_pair_before_sync_chk: assert property (@(posedge clk) disable iff (rst)
    !seen_sync |-> !pair_vld);

  // R3
  word_order_chk: assert property (@(posedge clk) disable iff (rst)
    pair_vld |-> ({i_out, q_out} ==
      {$past(word_in, 4), $past(word_in, 3), $past(word_in, 2), $past(word_in, 1)}));

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pair_vld |=> !pair_vld);

  // R5
  hold_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    !pair_vld |-> ($stable(i_out) && $stable(q_out)));

  // R8
  pair_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    pair_vld |-> (gap == 2'd3));
endmodule

bind iq_word_assembler iqa_checker #(.WORD_W(WORD_W)) u_iqa_checker (
  .clk       (clk),
  .rst       (rst),
  .sym_start (sym_start),
  .word_in   (word_in),
  .i_out     (i_out),
  .q_out     (q_out),
  .pair_vld  (pair_vld)
);

// File: tb/test_iq_word_assembler.sv
module test_iq_word_assembler;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 6;
  localparam int COMP_W = 2 * WORD_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sym_start = 1'b0;
  logic [WORD_W-1:0] word_in = '0;
  logic [COMP_W-1:0] i_out, q_out;
  logic              pair_vld;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  bit                m_armed = 1'b0;
  int                m_ph = 0;
  logic [WORD_W-1:0] m_buf [4];
  bit                e_vld = 1'b0;
  logic [COMP_W-1:0] e_i = '0, e_q = '0;

  iq_word_assembler #(.WORD_W(WORD_W)) i_iq_word_assembler (
    .clk(clk), .rst(rst), .sym_start(sym_start), .word_in(word_in),
    .i_out(i_out), .q_out(q_out), .pair_vld(pair_vld)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [COMP_W-1:0] join_words(input logic [WORD_W-1:0] hi,
                                                   input logic [WORD_W-1:0] lo);
    return {hi, lo};
  endfunction

  task automatic model_step(input bit s, input logic [WORD_W-1:0] w);
    int ph;
    e_vld = 1'b0;
    if (s || m_armed) begin
      ph = s ? 0 : m_ph;
      m_buf[ph] = w;
      if (ph == 3) begin
        e_vld = 1'b1;
        e_i = join_words(m_buf[0], m_buf[1]);
        e_q = join_words(m_buf[2], w);
      end
      m_ph = (ph + 1) % 4;
      m_armed = 1'b1;
    end
  endtask

  // drive one word, clock it in, then compare against the model
  task automatic step(input bit s, input logic [WORD_W-1:0] w, input string tag);
    sym_start = s;
    word_in   = w;
    @(posedge clk);
    model_step(s, w);
    #1;
    check(pair_vld == e_vld, tag, "pair_vld", 32'(pair_vld), 32'(e_vld));
    check(i_out == e_i, tag, "i_out", 32'(i_out), 32'(e_i));
    check(q_out == e_q, tag, "q_out", 32'(q_out), 32'(e_q));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'h1dc0de);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(pair_vld == 1'b0 && i_out == '0 && q_out == '0, "R1", "reset outputs",
          {7'd0, pair_vld, i_out, q_out}, 32'd0);
    rst = 1'b0;
    @(posedge clk); #1;
    check(pair_vld == 1'b0 && i_out == '0 && q_out == '0, "R1", "first cycle after reset",
          {7'd0, pair_vld, i_out, q_out}, 32'd0);

    // R2: words before any strobe are ignored
    for (int k = 0; k < 9; k++) step(1'b0, WORD_W'(k + 7), "R2");

    // R3, R4: one symbol with known words; I negative, Q positive
    step(1'b1, 6'h2A, "R3");
    step(1'b0, 6'h15, "R3");
    step(1'b0, 6'h0C, "R4");
    step(1'b0, 6'h33, "R4");
    check(i_out == 12'hA95, "R3", "i_out value", 32'(i_out), 32'hA95);
    check($signed(i_out) < 0, "R3", "i_out sign", 32'(i_out), 32'hA95);
    check(q_out == 12'h333, "R4", "q_out value", 32'(q_out), 32'h333);
    check(pair_vld == 1'b1, "R5", "valid after fourth word", 32'(pair_vld), 32'd1);

    // R6: next symbol without strobe
    step(1'b0, 6'h01, "R6");
    check(pair_vld == 1'b0, "R5", "single cycle pulse", 32'(pair_vld), 32'd0);
    step(1'b0, 6'h02, "R6");
    step(1'b0, 6'h03, "R6");
    step(1'b0, 6'h04, "R6");
    check(i_out == 12'h042 && q_out == 12'h0C4, "R6", "unstrobed symbol",
          {i_out, q_out[11:0], 8'd0}, {12'h042, 12'h0C4, 8'd0});

    // R7: strobe during third word aborts the partial symbol
    step(1'b0, 6'h3F, "R7");
    step(1'b0, 6'h3E, "R7");
    step(1'b1, 6'h05, "R7");
    step(1'b0, 6'h06, "R7");
    check(pair_vld == 1'b0, "R7", "no pair for aborted symbol", 32'(pair_vld), 32'd0);
    step(1'b0, 6'h07, "R7");
    step(1'b0, 6'h08, "R7");
    check(i_out == 12'h146 && q_out == 12'h1C8, "R7", "restarted symbol",
          {i_out, q_out[11:0], 8'd0}, {12'h146, 12'h1C8, 8'd0});

    // R7: strobe on the fourth word
    step(1'b1, 6'h11, "R7");
    step(1'b0, 6'h12, "R7");
    step(1'b0, 6'h13, "R7");
    step(1'b1, 6'h21, "R7");
    check(pair_vld == 1'b0, "R7", "strobe on fourth word", 32'(pair_vld), 32'd0);
    step(1'b0, 6'h22, "R7");
    step(1'b0, 6'h23, "R7");
    step(1'b0, 6'h24, "R7");

    // R5, R8: random stream with occasional strobes
    begin
      int last_vld = -100;
      for (int n = 0; n < 3000; n++) begin
        step(($urandom % 16) == 0, WORD_W'($urandom), "R5");
        if (pair_vld) begin
          check(n - last_vld >= 4, "R8", "pair spacing", 32'(n - last_vld), 32'd4);
          last_vld = n;
        end
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule